// File: doc/BRIEF.md
# Two-Port Burst SRAM Host Controller

This controller sits between on-chip logic and an external synchronous SRAM that has a separate read data port and a separate write data port. The SRAM has one address bus that both ports share. The read port and the write port each take requests through their own valid/ready handshake. A read request carries an address. A write request carries an address, two data beats and a per-beat byte-enable mask. The controller turns these requests into the memory's pin-level sequence: active-low port selects, the shared address split across the two phases of the memory clock, two write beats with active-low byte strobes, and capture of the two read beats that return after a fixed latency.

Each memory clock cycle has a rising phase and a falling phase. The controller presents the value for each phase on its own registered bus, and an output cell outside this block serialises the pair onto the wire. The read address goes on the rising phase and the write address on the falling phase. A read and a write accepted in the same cycle are therefore issued together in one memory cycle.

A shift register, as deep as the configured read latency, tracks each issued read. When a read's two return beats arrive, the controller captures them as one double-width word and pulses a response valid for one cycle.

Top module: `burst_sram_host`

## Requirements
- R1: While `rst` is high, both selects are high, every byte strobe is high, `rsp_valid` is low, and both ready outputs are low.
- R2: A read accepted at a clock edge (`rd_valid` and `rd_ready` both high) drives `mem_rsel_n` low and `mem_addr_rise` to the request address for the one cycle that follows that edge.
- R3: A write accepted at an edge drives the following for the next cycle: `mem_wsel_n` low, `mem_addr_fall` set to the request address, `mem_d_rise` set to beat 0 and `mem_d_fall` set to beat 1.
- R4: On a write cycle, byte strobe bit k is the inverse of enable bit k (`mem_be_n_rise` from `wr_en0`, `mem_be_n_fall` from `wr_en1`). With the default 18-bit word, lane k covers data bits [9k+8:9k]. With a word width that is not a multiple of 9, the lanes are 4 bits wide.
- R5: A read and a write accepted at the same edge are both issued in the next cycle, each on its own address phase.
- R6: In a cycle with no accepted read, `mem_rsel_n` is high and `mem_addr_rise` keeps its previous value, whatever `rd_addr` carries. In a cycle with no accepted write, `mem_wsel_n` is high, `mem_addr_fall` holds, and all strobes are high.
- R7: For a read accepted at edge a, the controller samples `mem_q_rise` and `mem_q_fall` at edge a+READ_LAT. In the cycle after that edge, `rsp_valid` is high and `rsp_data` = {second beat, first beat}, with the first beat in the low half.
- R8: Reads accepted on consecutive edges give responses on consecutive cycles, in the order they were accepted.
- R9: From the first edge after reset is released, both ready outputs stay high, so one read and one write can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request can be taken |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request can be taken |
| wr_addr | input | AW | Write address |
| wr_beat0 | input | W | First write beat |
| wr_beat1 | input | W | Second write beat |
| wr_en0 | input | LANES | Active-high lane enables for beat 0 |
| wr_en1 | input | LANES | Active-high lane enables for beat 1 |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_data | output | 2*W | {second beat, first beat} |
| mem_rsel_n | output | 1 | Read port select, active low |
| mem_wsel_n | output | 1 | Write port select, active low |
| mem_addr_rise | output | AW | Address for the rising phase (read) |
| mem_addr_fall | output | AW | Address for the falling phase (write) |
| mem_d_rise | output | W | Write beat for the rising phase |
| mem_d_fall | output | W | Write beat for the falling phase |
| mem_be_n_rise | output | LANES | Active-low strobes for the rising-phase beat |
| mem_be_n_fall | output | LANES | Active-low strobes for the falling-phase beat |
| mem_q_rise | input | W | Returned first read beat |
| mem_q_fall | input | W | Returned second read beat |

## Verification
The stimulus table covers the following patterns, each separating one kind of fault:
- A lone write followed by a lone read shows whether the beats land in the correct halves.
- A write whose two beats carry complementary lane masks shows whether each strobe comes from the enable set of its own beat.
- A read and a write to the same address in one cycle shows whether the read returns the old contents and whether the two addresses sit on their own phases.
- Idle cycles with junk on the address inputs show whether requests that were not accepted leak through.

A random phase then runs dense back-to-back interleaved traffic against a behavioural memory and a shadow array. Each response is checked for both its data and its exact arrival cycle, which exposes latency errors and ordering errors.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  // Wide words split into 9-bit lanes; otherwise 4-bit lanes.
  function automatic int lane_width(input int w);
    return (w % 9 == 0) ? 9 : 4;
  endfunction

  function automatic int lane_count(input int w);
    return w / lane_width(w);
  endfunction
endpackage

// File: rtl/bsh_rd_chan.sv
module bsh_rd_chan #(
  parameter int AW       = 8,
  parameter int W        = 18,
  parameter int READ_LAT = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  output logic           rsel_n,
  output logic [AW-1:0]  addr_rise,
  input  logic [W-1:0]   q_rise,
  input  logic [W-1:0]   q_fall,
  output logic           rsp_valid,
  output logic [2*W-1:0] rsp_data
);
  localparam int CW = $clog2(READ_LAT + 2) + 1;

  logic                accept;
  logic [READ_LAT-1:0] track;
  logic                capture;
  logic [CW-1:0]       owed;

  assign accept  = req_valid & req_ready;
  assign capture = track[READ_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsel_n    <= 1'b1;
      addr_rise <= '0;
    end else begin
      req_ready <= 1'b1;
      rsel_n    <= ~accept;
      if (accept) addr_rise <= req_addr;
    end
  end

  // One bit per issued read, walking toward the capture point.
  generate
    if (READ_LAT == 1) begin : g_trk1
      always_ff @(posedge clk) track <= rst ? '0 : accept;
    end else begin : g_trkn
      always_ff @(posedge clk)
        track <= rst ? '0 : {track[READ_LAT-2:0], accept};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= capture;
    if (capture) rsp_data <= {q_fall, q_rise};
  end

  // Checker state: reads issued but not yet answered.
  always_ff @(posedge clk) begin
    if (rst) owed <= '0;
    else     owed <= owed + CW'(accept) - CW'(rsp_valid);
  end

  p_rsel_issue_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!rsel_n && addr_rise == $past(req_addr)))
    else $error("R2 read select/address not issued");

  p_rsel_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (rsel_n && $stable(addr_rise)))
    else $error("R6 read port not idle");

  p_rsp_owed_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (owed != '0))
    else $error("R7 response without a read");

  p_owed_bound_r8: assert property (@(posedge clk) disable iff (rst)
    owed <= CW'(READ_LAT + 1))
    else $error("R8 too many reads in flight");
endmodule

// File: rtl/bsh_wr_chan.sv
module bsh_wr_chan #(
  parameter int AW    = 8,
  parameter int W     = 18,
  parameter int LANES = bsh_pkg::lane_count(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [W-1:0]     req_d0,
  input  logic [W-1:0]     req_d1,
  input  logic [LANES-1:0] req_en0,
  input  logic [LANES-1:0] req_en1,
  output logic             wsel_n,
  output logic [AW-1:0]    addr_fall,
  output logic [W-1:0]     d_rise,
  output logic [W-1:0]     d_fall,
  output logic [LANES-1:0] be_n_rise,
  output logic [LANES-1:0] be_n_fall
);
  logic             accept;
  logic [LANES-1:0] inv0, inv1;

  assign accept = req_valid & req_ready;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign inv0[k] = ~req_en0[k];
      assign inv1[k] = ~req_en1[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      wsel_n    <= 1'b1;
      addr_fall <= '0;
      d_rise    <= '0;
      d_fall    <= '0;
      be_n_rise <= '1;
      be_n_fall <= '1;
    end else begin
      req_ready <= 1'b1;
      wsel_n    <= ~accept;
      be_n_rise <= accept ? inv0 : '1;
      be_n_fall <= accept ? inv1 : '1;
      if (accept) begin
        addr_fall <= req_addr;
        d_rise    <= req_d0;
        d_fall    <= req_d1;
      end
    end
  end

  p_wsel_issue_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!wsel_n && addr_fall == $past(req_addr)
                && d_rise == $past(req_d0) && d_fall == $past(req_d1)))
    else $error("R3 write not issued");

  p_strobe_inv_r4: assert property (@(posedge clk) disable iff (rst)
    accept |=> (be_n_rise == ~$past(req_en0) && be_n_fall == ~$past(req_en1)))
    else $error("R4 strobes not inverted enables");

  p_strobe_idle_r6: assert property (@(posedge clk) disable iff (rst)
    wsel_n |-> (&be_n_rise && &be_n_fall))
    else $error("R6 strobe active while deselected");

  p_wr_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (wsel_n && $stable(addr_fall)))
    else $error("R6 write address moved while idle");
endmodule

// File: rtl/burst_sram_host.sv
module burst_sram_host #(
  parameter int AW       = 8,
  parameter int W        = 18,
  parameter int READ_LAT = 3,
  parameter int LANES    = bsh_pkg::lane_count(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_beat0,
  input  logic [W-1:0]     wr_beat1,
  input  logic [LANES-1:0] wr_en0,
  input  logic [LANES-1:0] wr_en1,
  output logic             rsp_valid,
  output logic [2*W-1:0]   rsp_data,
  output logic             mem_rsel_n,
  output logic             mem_wsel_n,
  output logic [AW-1:0]    mem_addr_rise,
  output logic [AW-1:0]    mem_addr_fall,
  output logic [W-1:0]     mem_d_rise,
  output logic [W-1:0]     mem_d_fall,
  output logic [LANES-1:0] mem_be_n_rise,
  output logic [LANES-1:0] mem_be_n_fall,
  input  logic [W-1:0]     mem_q_rise,
  input  logic [W-1:0]     mem_q_fall
);
  bsh_rd_chan #(.AW(AW), .W(W), .READ_LAT(READ_LAT)) u_rd (
    .clk(clk), .rst(rst),
    .req_valid(rd_valid), .req_ready(rd_ready), .req_addr(rd_addr),
    .rsel_n(mem_rsel_n), .addr_rise(mem_addr_rise),
    .q_rise(mem_q_rise), .q_fall(mem_q_fall),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  bsh_wr_chan #(.AW(AW), .W(W), .LANES(LANES)) u_wr (
    .clk(clk), .rst(rst),
    .req_valid(wr_valid), .req_ready(wr_ready), .req_addr(wr_addr),
    .req_d0(wr_beat0), .req_d1(wr_beat1),
    .req_en0(wr_en0), .req_en1(wr_en1),
    .wsel_n(mem_wsel_n), .addr_fall(mem_addr_fall),
    .d_rise(mem_d_rise), .d_fall(mem_d_fall),
    .be_n_rise(mem_be_n_rise), .be_n_fall(mem_be_n_fall)
  );

  p_dual_issue_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && wr_valid && wr_ready) |=> (!mem_rsel_n && !mem_wsel_n))
    else $error("R5 concurrent read/write not issued together");

  p_ready_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rd_ready && wr_ready))
    else $error("R9 ready dropped");
endmodule

// File: tb/tb_burst_sram_host.sv
module tb_burst_sram_host;
  localparam int AW = 8, W = 18, RL = 3, LN = 2, LW = 9;
  localparam int VW = 1 + AW + 1 + AW + W + W + LN + LN;
  localparam int NV = 10;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic rd_valid = 0, wr_valid = 0, rd_ready, wr_ready, rsp_valid;
  logic [AW-1:0] rd_addr = 0, wr_addr = 0, mem_addr_rise, mem_addr_fall;
  logic [W-1:0] wr_beat0 = 0, wr_beat1 = 0, mem_d_rise, mem_d_fall, mem_q_rise, mem_q_fall;
  logic [LN-1:0] wr_en0 = 0, wr_en1 = 0, mem_be_n_rise, mem_be_n_fall;
  logic [2*W-1:0] rsp_data;
  logic mem_rsel_n, mem_wsel_n;

  burst_sram_host #(.AW(AW), .W(W), .READ_LAT(RL)) dut (.*);

  // Behavioural memory: samples at the edge after select, returns after RL-1 more edges.
  logic [W-1:0] m0 [0:(1<<AW)-1];
  logic [W-1:0] m1 [0:(1<<AW)-1];
  logic [W-1:0] qp [1:RL-1];
  logic [W-1:0] qn [1:RL-1];
  assign mem_q_rise = qp[RL-1];
  assign mem_q_fall = qn[RL-1];
  always @(posedge clk) begin
    qp[1] <= !mem_rsel_n ? m0[mem_addr_rise] : '0;
    qn[1] <= !mem_rsel_n ? m1[mem_addr_rise] : '0;
    for (int i = 2; i < RL; i++) begin qp[i] <= qp[i-1]; qn[i] <= qn[i-1]; end
    if (!mem_wsel_n)
      for (int k = 0; k < LN; k++) begin
        if (!mem_be_n_rise[k]) m0[mem_addr_fall][k*LW +: LW] <= mem_d_rise[k*LW +: LW];
        if (!mem_be_n_fall[k]) m1[mem_addr_fall][k*LW +: LW] <= mem_d_fall[k*LW +: LW];
      end
  end

  // Shadow contents and expected responses.
  logic [W-1:0] s0 [0:(1<<AW)-1];
  logic [W-1:0] s1 [0:(1<<AW)-1];
  logic [2*W-1:0] exp_d [0:255];
  int exp_due [0:255];
  int head = 0, tail = 0, now = 0, nrun = 0, nfail = 0;
  logic [AW-1:0] last_ra = 0, last_wa = 0;
  bit done = 0;

  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {1'b0, 8'h00, 1'b1, 8'h03, 18'h12345, 18'h2ABCD, 2'b11, 2'b11},
    {1'b0, 8'h00, 1'b1, 8'h05, 18'h00F0F, 18'h3F0F0, 2'b11, 2'b11},
    {1'b1, 8'h03, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b00, 2'b00},
    {1'b1, 8'h05, 1'b1, 8'h03, 18'h3FFFF, 18'h00000, 2'b01, 2'b10},
    {1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b00, 2'b00},
    {1'b1, 8'h03, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b00, 2'b00},
    {1'b1, 8'h03, 1'b1, 8'h03, 18'h00001, 18'h00002, 2'b11, 2'b11},
    {1'b0, 8'h00, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b00, 2'b00},
    {1'b1, 8'h03, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b00, 2'b00},
    {1'b1, 8'h05, 1'b0, 8'h00, 18'h00000, 18'h00000, 2'b00, 2'b00}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive one cycle, then check ports and responses.
  task automatic step(input bit rv, input logic [AW-1:0] ra, input bit wv, input logic [AW-1:0] wa,
                      input logic [W-1:0] d0, input logic [W-1:0] d1,
                      input logic [LN-1:0] e0, input logic [LN-1:0] e1);
    rd_valid = rv; wr_valid = wv;
    rd_addr = rv ? ra : AW'($urandom);   // junk when idle must be ignored
    wr_addr = wv ? wa : AW'($urandom);
    wr_beat0 = d0; wr_beat1 = d1; wr_en0 = e0; wr_en1 = e1;
    if (rv) begin
      exp_d[tail[7:0]] = {s1[ra], s0[ra]};   // same-cycle write not yet visible
      exp_due[tail[7:0]] = now + 1 + RL;
      tail++;
    end
    if (wv)
      for (int k = 0; k < LN; k++) begin
        if (e0[k]) s0[wa][k*LW +: LW] = d0[k*LW +: LW];
        if (e1[k]) s1[wa][k*LW +: LW] = d1[k*LW +: LW];
      end
    @(posedge clk); @(negedge clk); now++;
    if (rv) begin
      chk(!mem_rsel_n, "R2 rsel", 64'(mem_rsel_n), 0);
      chk(mem_addr_rise == ra, "R2 addr_rise", 64'(mem_addr_rise), 64'(ra));
      last_ra = ra;
    end else begin
      chk(mem_rsel_n && mem_addr_rise == last_ra, "R6 read idle hold", 64'(mem_addr_rise), 64'(last_ra));
    end
    if (wv) begin
      chk(!mem_wsel_n && mem_addr_fall == wa, "R3 wsel/addr_fall", 64'(mem_addr_fall), 64'(wa));
      chk(mem_d_rise == d0 && mem_d_fall == d1, "R3 beats", {mem_d_fall, mem_d_rise}, {d1, d0});
      chk(mem_be_n_rise == ~e0 && mem_be_n_fall == ~e1, "R4 strobes",
          {mem_be_n_fall, mem_be_n_rise}, {~e1, ~e0});
      last_wa = wa;
    end else begin
      chk(mem_wsel_n && mem_addr_fall == last_wa && &mem_be_n_rise && &mem_be_n_fall,
          "R6 write idle", {mem_be_n_fall, mem_be_n_rise, mem_addr_fall}, {4'hF, last_wa});
    end
    if (rv && wv)
      chk(!mem_rsel_n && !mem_wsel_n, "R5 dual issue", {mem_rsel_n, mem_wsel_n}, 0);
    if (rsp_valid) begin
      if (head == tail) chk(0, "R7 spurious response", 1, 0);
      else begin
        chk(exp_due[head[7:0]] == now, "R7 latency", 64'(now), 64'(exp_due[head[7:0]]));
        chk(rsp_data == exp_d[head[7:0]], "R7 R8 data", 64'(rsp_data), 64'(exp_d[head[7:0]]));
        head++;
      end
    end else if (head != tail && exp_due[head[7:0]] <= now) begin
      chk(0, "R7 missing response", 0, 1);
      head++;
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin m0[i] = 0; m1[i] = 0; s0[i] = 0; s1[i] = 0; end
    for (int i = 1; i < RL; i++) begin qp[i] = 0; qn[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_rsel_n && mem_wsel_n && !rsp_valid && !rd_ready && !wr_ready
        && &mem_be_n_rise && &mem_be_n_fall, "R1 reset state",
        {rd_ready, wr_ready, rsp_valid, mem_rsel_n, mem_wsel_n}, 5'b00011);
    rst = 0;
    @(posedge clk); @(negedge clk);
    chk(rd_ready && wr_ready, "R9 ready after reset", {rd_ready, wr_ready}, 2'b11);

    // Vector table walk.
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] x;
      x = VEC[v];
      step(x[VW-1], x[VW-2 -: AW], x[VW-2-AW], x[VW-3-AW -: AW],
           x[2*LN+2*W-1 -: W], x[2*LN+W-1 -: W], x[2*LN-1 -: LN], x[LN-1:0]);
    end
    repeat (RL + 2) step(0, 0, 0, 0, 0, 0, 0, 0);

    // Dense random interleaved traffic over a small address range.
    for (int n = 0; n < 400; n++) begin
      step(($urandom % 4) != 0, AW'($urandom % 16), ($urandom % 3) != 0, AW'($urandom % 16),
           W'($urandom), W'($urandom), LN'($urandom), LN'($urandom));
      chk(rd_ready && wr_ready, "R9 ready held", {rd_ready, wr_ready}, 2'b11);
    end
    repeat (RL + 2) step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(head == tail, "R8 all reads answered", 64'(tail - head), 0);

    // Reset mid-stream returns the reset state.
    rst = 1;
    @(posedge clk); @(negedge clk);
    chk(mem_rsel_n && mem_wsel_n && !rsp_valid && !rd_ready, "R1 re-reset",
        {rd_ready, rsp_valid, mem_rsel_n, mem_wsel_n}, 4'b0011);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nrun++; nfail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule